// File: doc/BRIEF.md
# Hamming-Distance-One Address Decoder March Sequencer

This block is a self-contained test controller for one single-port synchronous SRAM. Its target is slow switching in the address decoders: a select line that turns on late or turns off late. To expose this, the controller issues accesses in pairs. The two addresses of a pair differ in exactly one bit, and they are accessed on consecutive cycles, so a decoder line must switch on and another switch off within one clock.

A run starts with `start_i`. It first writes all-zero words to the whole array in ascending order. It then walks each bit position of the selected decoder field, lowest first. `col_mode_i` chooses which field is walked: the row field or the column field. For each bit position, four march elements follow one another:
- read zeros, write ones, in ascending pair order;
- read ones, write zeros, in ascending pair order;
- the same two operation lists again, in descending pair order.

Read data returns one cycle after the read and is compared with the expected solid word. The first mismatch is recorded, and a sticky fail flag is raised. `done_o` marks the end of the run.

Top module: `hd1_march_ctrl`

## Requirements
- R1: After reset, `done_o`, `fail_o` and `mem_en_o` are 0.
- R2: A run begins with N = 2^(ROW_W+COL_W) writes of the all-zero word, one per cycle, to addresses 0 through N-1 in ascending order. The address is {row, col}, with the row field in the upper ROW_W bits.
- R3: In the march phase, every address gets a read followed on the next cycle by a write to the same address. The two addresses of a pair differ in exactly one bit and are accessed on four consecutive cycles: read A, write A, read B, write B.
- R4: The first element for a bit mask m reads zeros and writes all-ones. The second reads all-ones and writes zeros. Both visit, in ascending order, every address a with bit m clear, each followed by a|m.
- R5: The third and fourth elements use the operation lists of the first and second. They visit, in descending order, every address a with bit m set, each followed by a&~m.
- R6: With `col_mode_i`=0 (sampled at start), the walked masks are address bits COL_W to COL_W+ROW_W-1. With `col_mode_i`=1, they are bits 0 to COL_W-1. Bit positions go lowest first, and each runs all four elements before the next.
- R7: A run performs exactly N·(1+8·FW) accesses, where FW is the walked field width. `done_o` then rises, with `mem_en_o` low, and stays high until the next accepted start.
- R8: Read data is sampled the cycle after the read and compared with the expected word. Any mismatch sets `fail_o`, which stays set until the next accepted start.
- R9: The first mismatch is kept: `fail_addr_o` holds its address, `fail_bit_o` the bit index within the walked field, and `fail_exp_o` the expected word. Later mismatches in the same run do not overwrite them.
- R10: `start_i` is ignored while a run is active. In idle or done, it starts a new run and clears `fail_o`.
- R11: A fault-free memory finishes a run with `fail_o`=0 in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request |
| col_mode_i | input | 1 | 1: walk column field, 0: walk row field |
| mem_en_o | output | 1 | SRAM access enable |
| mem_we_o | output | 1 | SRAM write enable (0 = read) |
| mem_addr_o | output | ROW_W+COL_W | SRAM address {row, col} |
| mem_wdata_o | output | DATA_W | SRAM write data |
| mem_rdata_i | input | DATA_W | SRAM read data, one cycle after read |
| done_o | output | 1 | Run complete |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_addr_o | output | ROW_W+COL_W | Address of first mismatch |
| fail_bit_o | output | max(1,clog2(max(ROW_W,COL_W))) | Field bit index of first mismatch |
| fail_exp_o | output | DATA_W | Expected word of first mismatch |

## Verification
Each run is tried against a behavioural SRAM in one of three conditions:
- **Clean memory:** confirms the full access order and the run length in both field modes.
- **Cell with a stuck data bit:** it fails on every bit pass, so it shows that the first failure record is kept.
- **Late decoder switch:** a read returns the previously accessed word only when it follows an access one bit away in a chosen position.

The decoder-delay pattern separates the modes. A delay on a row bit is caught in row mode and missed in column mode, and a column-bit delay is caught in column mode. A start pulse in mid-run and a restart after a failing run exercise the start handling.

// File: rtl/hd1_pkg.sv
package hd1_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INIT  = 2'd1,
    ST_MARCH = 2'd2,
    ST_DONE  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/hd1_addr_gen.sv
module hd1_addr_gen #(
  parameter int ROW_W = 3,
  parameter int COL_W = 2,
  parameter int BW    = 2,
  localparam int AW   = ROW_W + COL_W
) (
  input  logic [AW-2:0] pidx_i,
  input  logic [BW-1:0] bit_i,
  input  logic          col_mode_i,
  input  logic          desc_i,
  input  logic          half_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] sel, low_mask, ext, base, partner;

  always_comb begin
    if (col_mode_i) sel = AW'(1) << bit_i;
    else            sel = AW'(1) << (bit_i + COL_W);
    low_mask = sel - 1'b1;
    // descending walk: reversed pair index
    ext      = {1'b0, (desc_i ? ~pidx_i : pidx_i)};
    base     = ((ext & ~low_mask) << 1) | (ext & low_mask);
    partner  = base | sel;
    addr_o   = (half_i ^ desc_i) ? partner : base;
  end
endmodule

// File: rtl/hd1_seq.sv
module hd1_seq
  import hd1_pkg::*;
#(
  parameter int ROW_W = 3,
  parameter int COL_W = 2,
  parameter int BW    = 2,
  localparam int AW   = ROW_W + COL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          col_mode_i,
  output seq_st_e       st_o,
  output logic          mode_o,
  output logic          start_acc_o,
  output logic [AW-1:0] init_addr_o,
  output logic [AW-2:0] pidx_o,
  output logic          half_o,
  output logic          op_o,
  output logic [1:0]    elem_o,
  output logic [BW-1:0] bit_o
);
  seq_st_e       st_q;
  logic [AW:0]   cnt_q;
  logic [1:0]    elem_q;
  logic [BW-1:0] bit_q, fw_last;
  logic          mode_q, init_last, elem_last;

  assign start_acc_o = start_i && (st_q == ST_IDLE || st_q == ST_DONE);
  assign init_last   = &cnt_q[AW-1:0];
  assign elem_last   = &cnt_q;
  assign fw_last     = mode_q ? BW'(COL_W - 1) : BW'(ROW_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      elem_q <= '0;
      bit_q  <= '0;
      mode_q <= 1'b0;
    end else if (start_acc_o) begin
      st_q   <= ST_INIT;
      cnt_q  <= '0;
      elem_q <= '0;
      bit_q  <= '0;
      mode_q <= col_mode_i;
    end else begin
      case (st_q)
        ST_INIT: begin
          cnt_q <= init_last ? '0 : cnt_q + 1'b1;
          if (init_last) st_q <= ST_MARCH;
        end
        ST_MARCH: begin
          cnt_q <= cnt_q + 1'b1;
          if (elem_last) begin
            elem_q <= elem_q + 1'b1;
            if (elem_q == 2'd3) begin
              if (bit_q == fw_last) st_q <= ST_DONE;
              else                  bit_q <= bit_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign st_o        = st_q;
  assign mode_o      = mode_q;
  assign init_addr_o = cnt_q[AW-1:0];
  assign op_o        = cnt_q[0];
  assign half_o      = cnt_q[1];
  assign pidx_o      = cnt_q[AW:2];
  assign elem_o      = elem_q;
  assign bit_o       = bit_q;

  // R7
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DONE && !start_i) |=> st_q == ST_DONE)
    else $error("done not held");

  // R10
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_MARCH && start_i) |=> st_q != ST_INIT)
    else $error("start accepted while busy");
endmodule

// File: rtl/hd1_resp_chk.sv
module hd1_resp_chk #(
  parameter int AW     = 5,
  parameter int DATA_W = 8,
  parameter int BW     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BW-1:0]     bit_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              fail_o,
  output logic [AW-1:0]     fail_addr_o,
  output logic [BW-1:0]     fail_bit_o,
  output logic [DATA_W-1:0] fail_exp_o
);
  logic              pend_q, mism;
  logic [DATA_W-1:0] exp_q;
  logic [AW-1:0]     addr_q;
  logic [BW-1:0]     bit_q;

  assign mism = pend_q && (rdata_i != exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      exp_q       <= '0;
      addr_q      <= '0;
      bit_q       <= '0;
      fail_o      <= 1'b0;
      fail_addr_o <= '0;
      fail_bit_o  <= '0;
      fail_exp_o  <= '0;
    end else if (clear_i) begin
      pend_q      <= 1'b0;
      fail_o      <= 1'b0;
      fail_addr_o <= '0;
      fail_bit_o  <= '0;
      fail_exp_o  <= '0;
    end else begin
      pend_q <= rd_i;
      if (rd_i) begin
        exp_q  <= exp_i;
        addr_q <= addr_i;
        bit_q  <= bit_i;
      end
      if (mism && !fail_o) begin
        fail_o      <= 1'b1;
        fail_addr_o <= addr_q;
        fail_bit_o  <= bit_q;
        fail_exp_o  <= exp_q;
      end
    end
  end

  // R8
  mism_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mism && !clear_i) |=> fail_o)
    else $error("mismatch not flagged");

  // R9
  first_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !clear_i) |=> fail_o && $stable(fail_addr_o) && $stable(fail_bit_o))
    else $error("failure record overwritten");
endmodule

// File: rtl/hd1_march_ctrl.sv
module hd1_march_ctrl
  import hd1_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 2,
  parameter int DATA_W = 8,
  localparam int AW     = ROW_W + COL_W,
  localparam int FW_MAX = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int BW     = (FW_MAX > 1) ? $clog2(FW_MAX) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              col_mode_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              fail_o,
  output logic [AW-1:0]     fail_addr_o,
  output logic [BW-1:0]     fail_bit_o,
  output logic [DATA_W-1:0] fail_exp_o
);
  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

  seq_st_e       st;
  logic          mode, start_acc, half, op, rd;
  logic [AW-1:0] init_addr, march_addr;
  logic [AW-2:0] pidx;
  logic [1:0]    elem;
  logic [BW-1:0] bit_idx;

  hd1_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .BW(BW)) u_seq (
    .clk_i, .rst_ni, .start_i, .col_mode_i,
    .st_o(st), .mode_o(mode), .start_acc_o(start_acc),
    .init_addr_o(init_addr), .pidx_o(pidx), .half_o(half), .op_o(op),
    .elem_o(elem), .bit_o(bit_idx)
  );

  hd1_addr_gen #(.ROW_W(ROW_W), .COL_W(COL_W), .BW(BW)) u_agen (
    .pidx_i(pidx), .bit_i(bit_idx), .col_mode_i(mode),
    .desc_i(elem[1]), .half_i(half), .addr_o(march_addr)
  );

  assign mem_en_o    = (st == ST_INIT) || (st == ST_MARCH);
  assign mem_we_o    = (st == ST_INIT) || (st == ST_MARCH && op);
  assign mem_addr_o  = (st == ST_INIT) ? init_addr : march_addr;
  // elements 0/2 write ones, 1/3 write zeros; init writes zeros
  assign mem_wdata_o = (st == ST_MARCH && !elem[0]) ? ONES : '0;
  assign rd          = (st == ST_MARCH) && !op;
  assign done_o      = (st == ST_DONE);

  hd1_resp_chk #(.AW(AW), .DATA_W(DATA_W), .BW(BW)) u_chk (
    .clk_i, .rst_ni, .clear_i(start_acc), .rd_i(rd),
    .exp_i(elem[0] ? ONES : '0), .addr_i(march_addr), .bit_i(bit_idx),
    .rdata_i(mem_rdata_i), .fail_o, .fail_addr_o, .fail_bit_o, .fail_exp_o
  );

  // R3
  rd_then_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && !mem_we_o) |=> mem_en_o && mem_we_o && mem_addr_o == $past(mem_addr_o))
    else $error("read not followed by write to same address");

  // R3
  pair_hd1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_MARCH && half && !op) |-> $countones(mem_addr_o ^ $past(mem_addr_o)) == 1)
    else $error("pair addresses not one bit apart");

  // R2
  init_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_INIT && $past(st) == ST_INIT) |-> mem_addr_o == AW'($past(mem_addr_o) + 1'b1))
    else $error("init not ascending");

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_en_o)
    else $error("access while done");
endmodule

// File: tb/tb_hd1_march_ctrl.sv
module tb_hd1_march_ctrl;
  localparam int ROW_W  = 3;
  localparam int COL_W  = 2;
  localparam int DATA_W = 8;
  localparam int AW     = ROW_W + COL_W;
  localparam int N      = 1 << AW;
  localparam int BW     = 2;
  localparam int MAXOP  = 1024;
  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

  // {mode, kind, fault addr, fault abs bit, exp fail, exp addr, exp field bit}
  localparam int NV = 8;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 2'd0, 5'd0,  3'd0, 1'b0, 5'd0,  2'd0},
    {1'b1, 2'd0, 5'd0,  3'd0, 1'b0, 5'd0,  2'd0},
    {1'b0, 2'd1, 5'd13, 3'd0, 1'b1, 5'd13, 2'd0},
    {1'b0, 2'd2, 5'd22, 3'd3, 1'b1, 5'd22, 2'd1},
    {1'b1, 2'd2, 5'd22, 3'd3, 1'b0, 5'd0,  2'd0},
    {1'b1, 2'd2, 5'd22, 3'd1, 1'b1, 5'd22, 2'd1},
    {1'b0, 2'd2, 5'd31, 3'd4, 1'b1, 5'd31, 2'd2},
    {1'b1, 2'd1, 5'd0,  3'd0, 1'b1, 5'd0,  2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, col_mode = 1'b0;
  logic mem_en, mem_we, done, fail;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DATA_W-1:0] mem_wdata, fail_exp;
  logic [DATA_W-1:0] rdata = '0;
  logic [BW-1:0] fail_bit;

  int total = 0, bad = 0;
  int f_kind = 0, f_addr = 0, f_pos = 0;

  logic [DATA_W-1:0] mem [N];
  logic [AW-1:0] prev_a = '0;
  logic [DATA_W-1:0] rv;

  logic [AW-1:0]     ea [MAXOP];
  logic              ew [MAXOP];
  logic [DATA_W-1:0] ed [MAXOP];
  int explen;

  always #2.5 clk = ~clk;

  hd1_march_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .col_mode_i(col_mode),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(rdata), .done_o(done),
    .fail_o(fail), .fail_addr_o(fail_addr), .fail_bit_o(fail_bit),
    .fail_exp_o(fail_exp)
  );

  // SRAM model with optional stuck data bit or late decoder switch
  always @(posedge clk) begin
    if (mem_en) begin
      prev_a <= mem_addr;
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else begin
        rv = mem[mem_addr];
        if (f_kind == 2 && int'(mem_addr) == f_addr &&
            int'(prev_a) == (f_addr ^ (1 << f_pos)))
          rv = mem[prev_a];
        if (f_kind == 1 && int'(mem_addr) == f_addr) rv[0] = 1'b1;
        rdata <= rv;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int a, input bit w, input logic [DATA_W-1:0] d);
    if (explen < MAXOP) begin
      ea[explen] = AW'(a);
      ew[explen] = w;
      ed[explen] = d;
    end
    explen++;
  endtask

  task automatic build(input bit mode);
    int fw, off;
    logic [DATA_W-1:0] r, w;
    explen = 0;
    fw  = mode ? COL_W : ROW_W;
    off = mode ? 0 : COL_W;
    for (int a = 0; a < N; a++) push(a, 1'b1, '0);
    for (int i = 0; i < fw; i++) begin
      for (int e = 0; e < 4; e++) begin
        int m;
        m = 1 << (off + i);
        r = (e % 2 == 1) ? ONES : '0;
        w = ~r;
        if (e < 2) begin
          for (int a = 0; a < N; a++)
            if ((a & m) == 0) begin
              push(a, 1'b0, r); push(a, 1'b1, w);
              push(a | m, 1'b0, r); push(a | m, 1'b1, w);
            end
        end else begin
          for (int a = N - 1; a >= 0; a--)
            if ((a & m) != 0) begin
              push(a, 1'b0, r); push(a, 1'b1, w);
              push(a ^ m, 1'b0, r); push(a ^ m, 1'b1, w);
            end
        end
      end
    end
  endtask

  task automatic run_one(input bit mode, input int kind, input int faddr, input int fpos,
                         input bit efail, input int eaddr, input int ebit, input int mid);
    int ops, seq_bad, cyc;
    f_kind = kind; f_addr = faddr; f_pos = fpos;
    build(mode);
    ops = 0; seq_bad = 0; cyc = 0;
    @(negedge clk); start = 1'b1; col_mode = mode;
    @(negedge clk); start = 1'b0;
    chk(fail == 1'b0, "R10 start clears fail", int'(fail), 0);
    while (!done && cyc < 4000) begin
      if (mem_en) begin
        if (ops >= MAXOP || mem_addr != ea[ops] || mem_we != ew[ops] ||
            (mem_we && mem_wdata != ed[ops]))
          seq_bad++;
        ops++;
      end
      @(negedge clk);
      cyc++;
      start = (mid != 0 && cyc == mid);
    end
    start = 1'b0;
    chk(cyc < 4000, "R7 run completes", cyc, 4000);
    // R2 R3 R4 R5 R6 access order
    chk(seq_bad == 0, "R2 R3 R4 R5 R6 access order mismatches", seq_bad, 0);
    chk(ops == explen, "R7 access count", ops, explen);
    chk(fail == efail, efail ? "R8 fault flagged" : "R11 clean run", int'(fail), int'(efail));
    if (efail) begin
      chk(int'(fail_addr) == eaddr, "R9 first fail address", int'(fail_addr), eaddr);
      chk(int'(fail_bit) == ebit, "R9 first fail bit index", int'(fail_bit), ebit);
      chk(fail_exp == '0, "R9 first fail expected word", int'(fail_exp), 0);
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(done == 1'b0 && fail == 1'b0 && mem_en == 1'b0, "R1 reset outputs",
        int'({done, fail, mem_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_en == 1'b0, "R1 idle after reset", int'(mem_en), 0);

    for (int v = 0; v < NV; v++) begin
      logic [18:0] t;
      t = VEC[v];
      run_one(t[18], int'(t[17:16]), int'(t[15:11]), int'(t[10:8]),
              t[7], int'(t[6:2]), int'(t[1:0]), 0);
    end

    // R7 done held, no accesses
    repeat (5) @(negedge clk);
    chk(done == 1'b1 && mem_en == 1'b0, "R7 done held idle", int'({done, mem_en}), 2);

    // R10 start mid-run ignored; run also restarts after a failing one
    run_one(1'b0, 0, 0, 0, 1'b0, 0, 0, 200);
    run_one(1'b1, 0, 0, 0, 1'b0, 0, 0, 50);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule